// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller. It groups its pins into ports of eight, and the number of ports is a parameter. Software reaches it over a simple 32-bit register bus. Each port keeps an output data byte, a 2-bit drive mode per pin and a pull-up disable mask. From these, every pin's pad output value, pad output enable and pull-up enable are produced. Raw pad inputs pass through a two-flop synchronizer. The synchronized value is then used for reading back and for edge detection.

Each pin can record a rising or a falling edge into a sticky event bit, which software acknowledges by writing ones. Each port raises its own interrupt line whenever an enabled event is pending or any bit of its force mask is set. A global control register gates edge capture with a run bit. It also holds a stored select bit and two read-only identification fields: the number of ports and a core version number.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register bit is 0, so pad_oe is all 0, pad_pu_en is all 1, pad_out is all 0 and irq is all 0.
- R2: The control word at byte offset 0x00 keeps bit 0 (run) and bit 1 (select) as writable bits. It reads the core version parameter in bits [8:2] and the port count in bits [15:9]; writes to these fields are ignored. All other bits read 0.
- R3: Port n occupies byte offsets 0x04+n*0x30 through +0x1C. Its words are, in order: synchronized input, output data, drive mode, pull-up disable, event, event enable, force, edge select. Read data appears with bus_rvalid high on the cycle after the read strobe, and a read of an unmapped word returns 0.
- R4: The input word returns the pad inputs after two register stages, and writes to it are ignored.
- R5: Pin j's mode is bits [2j+1:2j] of the 16-bit mode word: 00 input (never drives), 01 push-pull (always drives), 10 open-drain (drives only while its data bit is 0), 11 open-source (drives only while its data bit is 1). pad_out carries the data bit.
- R6: A 1 in bit j of the pull-up disable word turns pad_pu_en for pin j off; a 0 turns it on.
- R7: Edge select bit j = 1 records a rising edge of pin j and 0 records a falling edge. A recorded edge sets event bit j whatever the enable bit holds.
- R8: Writing a 1 to an event bit clears it, and writing a 0 leaves it unchanged.
- R9: A port's irq is a register that is set on the clock after (event AND enable) or force is non-zero, and cleared on the clock after both are zero.
- R10: While run is 0, no event is recorded, and edges that occur then are not recorded later. The other registers stay readable and writable.
- R11: Only bits [7:0] of the output, pull-up, event, enable, force and edge select words and bits [15:0] of the mode word are stored; the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | NUM_PORTS*8 | Raw pad inputs |
| pad_out | output | NUM_PORTS*8 | Pad output values |
| pad_oe | output | NUM_PORTS*8 | Pad output enables |
| pad_pu_en | output | NUM_PORTS*8 | Pad pull-up enables |
| irq | output | NUM_PORTS | Interrupt line, one per port |

## Verification
The bench builds the controller with three ports and core version 5. With these values the port-count field reads back as a value that differs from the default build. The last port sits at a non-trivial offset, so the address stride is exercised on a port other than 0. Per-port interrupt independence can be checked on ports 0 and 2 while port 1 carries the pull-up and input tests. Edge polarity, acknowledge, force and the frozen-capture mode are all driven on real pad transitions.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int PORT_PINS      = 8;
  localparam int MODE_W         = 2 * PORT_PINS;
  localparam int PORT_BASE_W    = 1;   // first port word (byte 0x04)
  localparam int PORT_STRIDE_W  = 12;  // port spacing in words (0x30 bytes)
  localparam int PORT_WORDS     = 8;

  localparam logic [2:0] RG_INPUT = 3'd0;
  localparam logic [2:0] RG_DATA  = 3'd1;
  localparam logic [2:0] RG_MODE  = 3'd2;
  localparam logic [2:0] RG_PULL  = 3'd3;
  localparam logic [2:0] RG_EVENT = 3'd4;
  localparam logic [2:0] RG_ENAB  = 3'd5;
  localparam logic [2:0] RG_FORCE = 3'd6;
  localparam logic [2:0] RG_EDGE  = 3'd7;

  typedef enum logic [1:0] {
    DRV_INPUT  = 2'b00,
    DRV_PUSH   = 2'b01,
    DRV_SINK   = 2'b10,
    DRV_SOURCE = 2'b11
  } drive_mode_e;

  function automatic logic drive_enable(input logic [1:0] mode, input logic bit_val);
    case (drive_mode_e'(mode))
      DRV_PUSH:   return 1'b1;
      DRV_SINK:   return ~bit_val;
      DRV_SOURCE: return bit_val;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 wr_en,
  input  logic [2:0]           idx,
  input  logic [MODE_W-1:0]    wdata,
  input  logic [PORT_PINS-1:0] pin_sync,
  output logic [31:0]          rd_word,
  output logic [PORT_PINS-1:0] pad_out,
  output logic [PORT_PINS-1:0] pad_oe,
  output logic [PORT_PINS-1:0] pad_pu_en,
  output logic                 irq
);
  logic [PORT_PINS-1:0] data_q, pull_q, evt_q, ena_q, frc_q, edge_q, prev_q;
  logic [MODE_W-1:0]    mode_q;
  logic [PORT_PINS-1:0] det, ack;

  assign det = run ? ((edge_q & pin_sync & ~prev_q) | (~edge_q & ~pin_sync & prev_q))
                   : '0;
  assign ack = (wr_en && idx == RG_EVENT) ? wdata[PORT_PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      mode_q <= '0;
      pull_q <= '0;
      ena_q  <= '0;
      frc_q  <= '0;
      edge_q <= '0;
      evt_q  <= '0;
      prev_q <= '0;
      irq    <= 1'b0;
    end else begin
      prev_q <= pin_sync;
      evt_q  <= (evt_q & ~ack) | det;
      irq    <= (|(evt_q & ena_q)) | (|frc_q);
      if (wr_en) begin
        case (idx)
          RG_DATA:  data_q <= wdata[PORT_PINS-1:0];
          RG_MODE:  mode_q <= wdata;
          RG_PULL:  pull_q <= wdata[PORT_PINS-1:0];
          RG_ENAB:  ena_q  <= wdata[PORT_PINS-1:0];
          RG_FORCE: frc_q  <= wdata[PORT_PINS-1:0];
          RG_EDGE:  edge_q <= wdata[PORT_PINS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (idx)
      RG_INPUT: rd_word[PORT_PINS-1:0] = pin_sync;
      RG_DATA:  rd_word[PORT_PINS-1:0] = data_q;
      RG_MODE:  rd_word[MODE_W-1:0]    = mode_q;
      RG_PULL:  rd_word[PORT_PINS-1:0] = pull_q;
      RG_EVENT: rd_word[PORT_PINS-1:0] = evt_q;
      RG_ENAB:  rd_word[PORT_PINS-1:0] = ena_q;
      RG_FORCE: rd_word[PORT_PINS-1:0] = frc_q;
      default:  rd_word[PORT_PINS-1:0] = edge_q;
    endcase
  end

  assign pad_out   = data_q;
  assign pad_pu_en = ~pull_q;

  for (genvar j = 0; j < PORT_PINS; j++) begin : g_pin
    assign pad_oe[j] = drive_enable(mode_q[2*j +: 2], data_q[j]);

    // R5
    input_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_q[2*j +: 2] == 2'b00) |-> !pad_oe[j]);
  end

  // R10
  frozen_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> ((evt_q & ~$past(evt_q)) == '0));

  // R8
  event_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == RG_EVENT) |=> ((evt_q & $past(wdata[PORT_PINS-1:0] & ~det)) == '0));

  // R9
  force_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (|frc_q) |=> irq);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|(evt_q & ena_q)) && !(|frc_q)) |=> !irq);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int          NUM_PORTS = 5,
  parameter int          ADDR_W    = 12,
  parameter logic [6:0]  CORE_VER  = 7'd3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic                           bus_rvalid,
  input  logic [NUM_PORTS*PORT_PINS-1:0] pad_in,
  output logic [NUM_PORTS*PORT_PINS-1:0] pad_out,
  output logic [NUM_PORTS*PORT_PINS-1:0] pad_oe,
  output logic [NUM_PORTS*PORT_PINS-1:0] pad_pu_en,
  output logic [NUM_PORTS-1:0]           irq
);
  localparam int AW   = ADDR_W - 2;
  localparam int NPIN = NUM_PORTS * PORT_PINS;

  logic [AW-1:0]  waddr;
  logic           ctrl_hit;
  logic [1:0]     ctrl_q;
  logic [31:0]    ctrl_word;
  logic [NPIN-1:0] pin_sync;
  logic [NUM_PORTS-1:0] port_hit;
  logic [NUM_PORTS-1:0][2:0]  port_idx;
  logic [NUM_PORTS-1:0][31:0] port_rd;
  logic [31:0]    rd_next;
  logic           unused_bits;

  assign unused_bits = ^{bus_wdata[31:MODE_W], bus_addr[1:0]};
  assign waddr       = bus_addr[ADDR_W-1:2];
  assign ctrl_hit    = (waddr == '0);
  assign ctrl_word   = {16'h0, 7'(NUM_PORTS), CORE_VER, ctrl_q};

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= 2'b00;
    else if (bus_sel && bus_wr && ctrl_hit) ctrl_q <= bus_wdata[1:0];
  end

  gpio_sync2 #(.WIDTH(NPIN)) i_sync (
    .clk(clk), .rst(rst), .d_async(pad_in), .d_sync(pin_sync)
  );

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
    localparam int BASE = PORT_BASE_W + n * PORT_STRIDE_W;
    logic [AW-1:0] offs;
    assign offs        = waddr - AW'(BASE);
    assign port_hit[n] = (waddr >= AW'(BASE)) && (offs < AW'(PORT_WORDS));
    assign port_idx[n] = offs[2:0];

    gpio_port_bank i_bank (
      .clk(clk), .rst(rst), .run(ctrl_q[0]),
      .wr_en(bus_sel && bus_wr && port_hit[n]),
      .idx(port_idx[n]), .wdata(bus_wdata[MODE_W-1:0]),
      .pin_sync(pin_sync[n*PORT_PINS +: PORT_PINS]),
      .rd_word(port_rd[n]),
      .pad_out(pad_out[n*PORT_PINS +: PORT_PINS]),
      .pad_oe(pad_oe[n*PORT_PINS +: PORT_PINS]),
      .pad_pu_en(pad_pu_en[n*PORT_PINS +: PORT_PINS]),
      .irq(irq[n])
    );
  end

  always_comb begin
    rd_next = ctrl_hit ? ctrl_word : 32'h0;
    for (int n = 0; n < NUM_PORTS; n++)
      if (port_hit[n]) rd_next = rd_next | port_rd[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) bus_rdata <= rd_next;
    end
  end

  // R2
  ctrl_ident_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && ctrl_hit) |=> (bus_rdata[15:2] == {7'(NUM_PORTS), CORE_VER}));

  // R3
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> bus_rvalid);
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NP*8-1:0] pad_in = '0;
  logic [NP*8-1:0] pad_out, pad_oe, pad_pu_en;
  logic [NP-1:0] irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl #(.NUM_PORTS(NP), .ADDR_W(AW), .CORE_VER(7'd5)) i_gpio_port_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en), .irq(irq)
  );

  function automatic logic [AW-1:0] ra(input int port, input int r);
    return AW'(4 + port * 48 + r * 4);
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read data appears
  always @(negedge clk) begin
    if (!rst && bus_rvalid && !done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3: unexpected read data %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata, e, t);
      end
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state at the pads
    check(32'(pad_oe), 32'h0, "R1 pad_oe");
    check(32'(pad_pu_en), 32'hFFFFFF, "R1 pad_pu_en");
    check(32'(pad_out), 32'h0, "R1 pad_out");
    check(32'(irq), 32'h0, "R1 irq");
    // R2 identification: count 3 at [15:9], version 5 at [8:2]
    bus_read(12'h000, 32'h614, "R1 R2 control after reset");
    bus_write(12'h000, 32'hFFFFFFFF);
    bus_read(12'h000, 32'h617, "R2 control writable bits only");
    // R11 / R3 output data on last port
    bus_write(ra(2, 1), 32'h1A5);
    bus_read(ra(2, 1), 32'hA5, "R11 R3 port2 output data");
    idle(1);
    check(32'(pad_out[23:16]), 32'hA5, "R5 pad_out port2");
    // R5 drive modes on port 0
    bus_write(ra(0, 2), 32'hFFFFE4E4);
    bus_write(ra(0, 1), 32'h0F);
    bus_read(ra(0, 2), 32'hE4E4, "R5 R11 mode word");
    idle(1);
    check(32'(pad_oe[7:0]), 32'h6A, "R5 output enables");
    // R6 pull-ups on port 1
    bus_write(ra(1, 3), 32'h0F);
    idle(1);
    check(32'(pad_pu_en[15:8]), 32'hF0, "R6 pull-up enables");
    // R4 input path
    pad_in[15:8] = 8'h3C;
    idle(4);
    bus_read(ra(1, 0), 32'h3C, "R4 input word");
    bus_write(ra(1, 0), 32'hFF);
    bus_read(ra(1, 0), 32'h3C, "R4 input write ignored");
    // R7 edges on port 0: pin0 rising, pin1 falling
    bus_write(ra(0, 7), 32'h01);
    pad_in[0] = 1'b1;
    idle(5);
    bus_read(ra(0, 4), 32'h01, "R7 rising edge event without enable");
    check(32'(irq), 32'h0, "R9 irq stays low when disabled");
    bus_write(ra(0, 5), 32'h01);
    idle(2);
    check(32'(irq), 32'h1, "R9 irq raised by enabled event");
    pad_in[1] = 1'b1;
    idle(5);
    pad_in[0] = 1'b0;
    idle(5);
    bus_read(ra(0, 4), 32'h01, "R7 wrong polarity ignored");
    pad_in[1] = 1'b0;
    idle(5);
    bus_read(ra(0, 4), 32'h03, "R7 falling edge event");
    // R8 acknowledge
    bus_write(ra(0, 4), 32'h01);
    bus_read(ra(0, 4), 32'h02, "R8 write one clears");
    idle(2);
    check(32'(irq), 32'h0, "R9 irq drops after acknowledge");
    bus_write(ra(0, 4), 32'h00);
    bus_read(ra(0, 4), 32'h02, "R8 write zero keeps");
    // R9 force on port 2
    bus_write(ra(2, 6), 32'h80);
    idle(2);
    check(32'(irq), 32'h4, "R9 force raises port2 irq");
    bus_write(ra(2, 6), 32'h00);
    idle(2);
    check(32'(irq), 32'h0, "R9 force released");
    // R10 frozen capture
    bus_write(12'h000, 32'h0);
    bus_read(12'h000, 32'h614, "R10 control off");
    pad_in[0] = 1'b1;
    idle(5);
    bus_read(ra(0, 4), 32'h02, "R10 no event while off");
    bus_write(ra(0, 5), 32'h03);
    bus_read(ra(0, 5), 32'h03, "R10 registers writable while off");
    bus_write(12'h000, 32'h1);
    idle(5);
    bus_read(ra(0, 4), 32'h02, "R10 missed edge not recorded later");
    // R3 unmapped gap
    bus_read(12'h028, 32'h0, "R3 unmapped read");
    idle(3);
    check(32'(exp_q.size()), 32'h0, "R3 all reads answered");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule